// File: doc/BRIEF.md
# Inline crypto keyslot register file

This block holds the key configuration slots used by the inline encryption path of a storage host controller. Software fills each slot through a simple register bus, one 32-bit dword per write. A slot is armed only when software writes its control dword with the enable bit set. The crypto datapath gives a slot number on the lookup port and gets back, one cycle later, the key material, the data-unit-size mask and the capability index of that slot, along with a valid flag.

A read-only capability word at byte 0 tells software how many slots exist and where the slot array begins. The array starts at byte `ARRAY_PTR * 0x100`. Each entry spans 128 bytes: dwords 0 to 15 carry up to 64 key bytes, dword 16 is the control word, dword 17 is a spare word that is stored as written, and dwords 18 to 31 are unused. To commit an entry, software clears dword 16, loads the key dwords and dword 17, and writes dword 16 last. An entry written with all zeros is an evicted slot. Reset leaves every slot in that state.

Top module: `ksl_keyslot_regs`

## Requirements
- R1: A read of byte address 0 returns `{8'h00, ARRAY_PTR[7:0], 8'h00, NUM_SLOTS-1}`. Bits [7:0] hold the slot count minus one and bits [23:16] hold the array pointer. Writes to that address change nothing.
- R2: Dword d of slot n sits at byte address `ARRAY_PTR*0x100 + n*128 + d*4`. Key dwords 0 to 15 and dword 17 read back exactly what was last written. `bus_rdata` takes the addressed value on the clock edge that samples `bus_rd`, and it holds that value while `bus_rd` is low.
- R3: Dword 16 has three fields: bits [7:0] are the data-unit-size mask, bits [15:8] are the capability index, and bit 31 is the enable bit. Its other bits read as zero.
- R4: Suppose a lookup is sampled on `lk_slot` for a slot that is in range and has its enable bit set. Then on the next edge `lk_valid` is 1 and `lk_key[32*i+31:32*i]` holds key dword i. So the second half of a split two-half key, which starts at key byte 32, appears in dword 8. `lk_du_mask` and `lk_cap_idx` carry that slot's fields.
- R5: A lookup on a slot whose enable bit is clear, or on a slot number of `NUM_SLOTS` or above, gives `lk_valid` 0 with `lk_key`, `lk_du_mask` and `lk_cap_idx` all zero.
- R6: A write to any key dword (0 to 15) of a slot clears that slot's enable bit. Read-back bit 31 then shows 0 and lookups report invalid until dword 16 is written again with bit 31 set. A write to dword 17 leaves the enable bit unchanged.
- R7: Writing dword 16 with bit 31 clear deactivates the slot. Writing all zeros to an entry evicts it, so every dword reads 0 and lookups are invalid.
- R8: After reset, every dword of every slot reads 0 and every lookup is invalid.
- R9: Writes to addresses outside the capability word and the slot array, and writes to dwords 18 to 31 of an entry, have no effect. Reads of those addresses return 0.
- R10: A lookup sampled on the same edge as a write sees the slot as it was before that write.
- R11: A write to one slot leaves the contents and state of every other slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears all slots |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address (bits [1:0] ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| lk_slot | input | $clog2(NUM_SLOTS)+1 | Slot number requested by the datapath |
| lk_valid | output | 1 | Requested slot is in range and enabled |
| lk_key | output | 512 | Key field; dword i at bits [32i+31:32i] |
| lk_du_mask | output | 8 | Data-unit-size mask of the slot |
| lk_cap_idx | output | 8 | Capability index of the slot |

## Verification
Software programming and datapath lookup can hit the same slot in the same cycle. The case that matters is a key-dword write to an enabled slot while that slot sits on `lk_slot`. The bench sets up this collision directly. It expects the lookup result from that edge to still show the old key with valid set, and the result from the next edge to show the slot invalid with zero data. A bound property separately checks that any key-dword write is followed by an invalid lookup of that slot. The random phase mixes writes, reads and lookups on the same few slots so that this overlap keeps recurring.

// File: rtl/ksl_pkg.sv
package ksl_pkg;
  localparam int DW_BITS     = 32;
  localparam int KEY_DWORDS  = 16;
  localparam int KEY_BITS    = KEY_DWORDS * DW_BITS;
  localparam int ENTRY_BYTES = 128;
  localparam int FIELD_W     = 8;
  localparam logic [4:0] CTRL_DW = 5'd16;
  localparam logic [4:0] AUX_DW  = 5'd17;

  typedef struct packed {
    logic               en;
    logic [FIELD_W-1:0] cap;
    logic [FIELD_W-1:0] mask;
  } slot_ctl_t;

  function automatic logic [DW_BITS-1:0] ctl_to_word(slot_ctl_t c);
    return {c.en, 15'd0, c.cap, c.mask};
  endfunction

  function automatic slot_ctl_t word_to_ctl(logic [DW_BITS-1:0] w);
    slot_ctl_t c;
    c.en   = w[31];
    c.cap  = w[15:8];
    c.mask = w[7:0];
    return c;
  endfunction
endpackage

// File: rtl/ksl_decode.sv
module ksl_decode #(
  parameter int NUM_SLOTS = 8,
  parameter int ARRAY_PTR = 1,
  parameter int ADDR_W    = 12
) (
  input  logic [ADDR_W-1:0]            addr,
  output logic                         is_cap,
  output logic                         in_arr,
  output logic [$clog2(NUM_SLOTS)-1:0] slot_idx,
  output logic [4:0]                   dw_idx
);
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam logic [ADDR_W:0] BASE_A = (ADDR_W+1)'(ARRAY_PTR * 256);
  localparam logic [ADDR_W:0] END_A  = (ADDR_W+1)'(ARRAY_PTR * 256 + NUM_SLOTS * ksl_pkg::ENTRY_BYTES);

  logic [ADDR_W-1:0] off;

  always_comb begin
    off      = addr - BASE_A[ADDR_W-1:0];
    is_cap   = (addr[ADDR_W-1:2] == '0);
    in_arr   = ({1'b0, addr} >= BASE_A) && ({1'b0, addr} < END_A);
    slot_idx = off[SLOT_W+6:7];
    dw_idx   = off[6:2];
  end
endmodule

// File: rtl/ksl_slot_store.sv
module ksl_slot_store import ksl_pkg::*; #(
  parameter int NUM_SLOTS = 8
) (
  input  logic                                           clk,
  input  logic                                           rst,
  input  logic                                           we,
  input  logic                                           in_arr,
  input  logic [$clog2(NUM_SLOTS)-1:0]                   slot_idx,
  input  logic [4:0]                                     dw_idx,
  input  logic [DW_BITS-1:0]                             wdata,
  output logic [NUM_SLOTS-1:0][KEY_DWORDS-1:0][DW_BITS-1:0] key_q,
  output slot_ctl_t [NUM_SLOTS-1:0]                      ctl_q,
  output logic [NUM_SLOTS-1:0][DW_BITS-1:0]              aux_q
);
  localparam int SLOT_W = $clog2(NUM_SLOTS);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [KEY_DWORDS-1:0][DW_BITS-1:0] key_r;
    slot_ctl_t                          ctl_r;
    logic [DW_BITS-1:0]                 aux_r;
    logic                               hit;

    assign hit = we && in_arr && (slot_idx == SLOT_W'(s));

    always_ff @(posedge clk) begin
      if (rst) begin
        key_r <= '0;
        ctl_r <= '0;
        aux_r <= '0;
      end else if (hit) begin
        if (dw_idx < CTRL_DW) begin
          key_r[dw_idx[3:0]] <= wdata;
          ctl_r.en           <= 1'b0;   // arming is lost until control is rewritten
        end else if (dw_idx == CTRL_DW) begin
          ctl_r <= word_to_ctl(wdata);
        end else if (dw_idx == AUX_DW) begin
          aux_r <= wdata;
        end
      end
    end

    assign key_q[s] = key_r;
    assign ctl_q[s] = ctl_r;
    assign aux_q[s] = aux_r;
  end
endmodule

// File: rtl/ksl_lookup.sv
module ksl_lookup import ksl_pkg::*; #(
  parameter int NUM_SLOTS = 8
) (
  input  logic                                              clk,
  input  logic                                              rst,
  input  logic [NUM_SLOTS-1:0][KEY_DWORDS-1:0][DW_BITS-1:0] key_q,
  input  slot_ctl_t [NUM_SLOTS-1:0]                         ctl_q,
  input  logic [$clog2(NUM_SLOTS):0]                        lk_slot,
  output logic                                              lk_valid,
  output logic [KEY_BITS-1:0]                               lk_key,
  output logic [FIELD_W-1:0]                                lk_du_mask,
  output logic [FIELD_W-1:0]                                lk_cap_idx
);
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam logic [SLOT_W:0] LIMIT = (SLOT_W+1)'(NUM_SLOTS);

  logic              in_rng;
  logic [SLOT_W-1:0] sel;
  logic              hit;

  always_comb begin
    in_rng = (lk_slot < LIMIT);
    sel    = lk_slot[SLOT_W-1:0];
    hit    = in_rng && ctl_q[sel].en;
  end

  always_ff @(posedge clk) begin
    if (rst || !hit) begin
      lk_valid   <= 1'b0;
      lk_key     <= '0;
      lk_du_mask <= '0;
      lk_cap_idx <= '0;
    end else begin
      lk_valid   <= 1'b1;
      lk_key     <= key_q[sel];
      lk_du_mask <= ctl_q[sel].mask;
      lk_cap_idx <= ctl_q[sel].cap;
    end
  end
endmodule

// File: rtl/ksl_keyslot_regs.sv
module ksl_keyslot_regs import ksl_pkg::*; #(
  parameter int NUM_SLOTS = 8,
  parameter int ARRAY_PTR = 1,
  parameter int ADDR_W    = 12
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [31:0]                  bus_wdata,
  output logic [31:0]                  bus_rdata,
  input  logic [$clog2(NUM_SLOTS):0]   lk_slot,
  output logic                         lk_valid,
  output logic [KEY_BITS-1:0]          lk_key,
  output logic [7:0]                   lk_du_mask,
  output logic [7:0]                   lk_cap_idx
);
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam logic [31:0] CAP_WORD = {8'd0, 8'(ARRAY_PTR), 8'd0, 8'(NUM_SLOTS - 1)};

  logic              is_cap, in_arr;
  logic [SLOT_W-1:0] slot_idx;
  logic [4:0]        dw_idx;

  logic [NUM_SLOTS-1:0][KEY_DWORDS-1:0][DW_BITS-1:0] key_q;
  slot_ctl_t [NUM_SLOTS-1:0]                         ctl_q;
  logic [NUM_SLOTS-1:0][DW_BITS-1:0]                 aux_q;

  ksl_decode #(.NUM_SLOTS(NUM_SLOTS), .ARRAY_PTR(ARRAY_PTR), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .is_cap(is_cap), .in_arr(in_arr),
    .slot_idx(slot_idx), .dw_idx(dw_idx)
  );

  ksl_slot_store #(.NUM_SLOTS(NUM_SLOTS)) u_store (
    .clk(clk), .rst(rst), .we(bus_wr), .in_arr(in_arr),
    .slot_idx(slot_idx), .dw_idx(dw_idx), .wdata(bus_wdata),
    .key_q(key_q), .ctl_q(ctl_q), .aux_q(aux_q)
  );

  ksl_lookup #(.NUM_SLOTS(NUM_SLOTS)) u_lk (
    .clk(clk), .rst(rst), .key_q(key_q), .ctl_q(ctl_q), .lk_slot(lk_slot),
    .lk_valid(lk_valid), .lk_key(lk_key),
    .lk_du_mask(lk_du_mask), .lk_cap_idx(lk_cap_idx)
  );

  logic [31:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (is_cap) begin
      rd_mux = CAP_WORD;
    end else if (in_arr) begin
      if (dw_idx < CTRL_DW)       rd_mux = key_q[slot_idx][dw_idx[3:0]];
      else if (dw_idx == CTRL_DW) rd_mux = ctl_to_word(ctl_q[slot_idx]);
      else if (dw_idx == AUX_DW)  rd_mux = aux_q[slot_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/ksl_keyslot_regs_chk.sv
module ksl_keyslot_regs_chk #(
  parameter int NUM_SLOTS = 8,
  parameter int ARRAY_PTR = 1,
  parameter int ADDR_W    = 12
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       bus_wr,
  input logic                       bus_rd,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [31:0]                bus_wdata,
  input logic [31:0]                bus_rdata,
  input logic [$clog2(NUM_SLOTS):0] lk_slot,
  input logic                       lk_valid,
  input logic [511:0]               lk_key,
  input logic [7:0]                 lk_du_mask,
  input logic [7:0]                 lk_cap_idx
);
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int BASE   = ARRAY_PTR * 256;
  localparam int LIMIT  = BASE + NUM_SLOTS * 128;
  localparam logic [31:0] CAP_WORD = {8'd0, 8'(ARRAY_PTR), 8'd0, 8'(NUM_SLOTS - 1)};

  logic              c_in;
  logic [4:0]        c_dw;
  logic [SLOT_W-1:0] c_slot;
  logic              kw_v;
  logic [SLOT_W-1:0] kw_slot;

  always_comb begin
    c_in   = (int'(bus_addr) >= BASE) && (int'(bus_addr) < LIMIT);
    c_dw   = bus_addr[6:2];
    c_slot = SLOT_W'((int'(bus_addr) - BASE) / 128);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kw_v    <= 1'b0;
      kw_slot <= '0;
    end else begin
      kw_v    <= bus_wr && c_in && (c_dw < 5'd16);
      kw_slot <= c_slot;
    end
  end

  AST_CAP_READ: assert property (@(posedge clk) disable iff (rst)
    bus_rd && (bus_addr[ADDR_W-1:2] == '0) |=> bus_rdata == CAP_WORD);  // R1
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));  // R2
  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rd && c_in && (c_dw == 5'd16) |=> bus_rdata[30:16] == 15'd0);  // R3
  AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |-> (lk_key == '0) && (lk_du_mask == 8'd0) && (lk_cap_idx == 8'd0));  // R5
  AST_OOR_INVALID: assert property (@(posedge clk) disable iff (rst)
    (int'(lk_slot) >= NUM_SLOTS) |=> !lk_valid);  // R5
  AST_KEYWR_DISARM: assert property (@(posedge clk) disable iff (rst)
    kw_v && (lk_slot == {1'b0, kw_slot}) |=> !lk_valid);  // R6
  AST_UNUSED_DW_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rd && c_in && (c_dw > 5'd17) |=> bus_rdata == 32'd0);  // R9
endmodule

bind ksl_keyslot_regs ksl_keyslot_regs_chk #(
  .NUM_SLOTS(NUM_SLOTS), .ARRAY_PTR(ARRAY_PTR), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/ksl_keyslot_regs_test.sv
module ksl_keyslot_regs_test;
  localparam int NS = 8;
  localparam int AP = 1;
  localparam int AW = 12;
  localparam int BASE = AP * 256;

  logic         clk = 1'b0;
  logic         rst;
  logic         bus_wr, bus_rd;
  logic [AW-1:0] bus_addr;
  logic [31:0]  bus_wdata, bus_rdata;
  logic [3:0]   lk_slot;
  logic         lk_valid;
  logic [511:0] lk_key;
  logic [7:0]   lk_du_mask, lk_cap_idx;

  ksl_keyslot_regs #(.NUM_SLOTS(NS), .ARRAY_PTR(AP), .ADDR_W(AW)) uut (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_key [NS][16];
  logic [7:0]  m_mask [NS];
  logic [7:0]  m_cap [NS];
  logic        m_en [NS];
  logic [31:0] m_aux [NS];

  function automatic logic [AW-1:0] adr(int s, int d);
    return AW'(BASE + s * 128 + d * 4);
  endfunction

  function automatic void model_reset();
    for (int s = 0; s < NS; s++) begin
      for (int d = 0; d < 16; d++) m_key[s][d] = '0;
      m_mask[s] = '0; m_cap[s] = '0; m_en[s] = 1'b0; m_aux[s] = '0;
    end
  endfunction

  function automatic void model_write(logic [AW-1:0] a, logic [31:0] v);
    int ai = int'(a);
    if (ai >= BASE && ai < BASE + NS * 128) begin
      int s = (ai - BASE) / 128;
      int d = (ai / 4) % 32;
      if (d < 16) begin m_key[s][d] = v; m_en[s] = 1'b0; end
      else if (d == 16) begin m_mask[s] = v[7:0]; m_cap[s] = v[15:8]; m_en[s] = v[31]; end
      else if (d == 17) m_aux[s] = v;
    end
  endfunction

  function automatic logic [31:0] model_read(logic [AW-1:0] a);
    int ai = int'(a);
    if (ai / 4 == 0) return {8'd0, 8'(AP), 8'd0, 8'(NS - 1)};
    if (ai >= BASE && ai < BASE + NS * 128) begin
      int s = (ai - BASE) / 128;
      int d = (ai / 4) % 32;
      if (d < 16) return m_key[s][d];
      if (d == 16) return {m_en[s], 15'd0, m_cap[s], m_mask[s]};
      if (d == 17) return m_aux[s];
    end
    return 32'd0;
  endfunction

  task automatic chk(string req, logic [511:0] act, logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] v);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
    model_write(a, v);
  endtask

  task automatic rd_check(string req, logic [AW-1:0] a);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(req, 512'(bus_rdata), 512'(model_read(a)));
  endtask

  task automatic lk_check(string req, int s);
    logic [511:0] ek = '0;
    logic ev;
    @(negedge clk);
    lk_slot = 4'(s);
    @(negedge clk);
    ev = (s < NS) && m_en[s];
    if (ev) for (int i = 0; i < 16; i++) ek[32*i +: 32] = m_key[s][i];
    chk(req, {lk_valid, lk_du_mask, lk_cap_idx, lk_key[494:0]},
             {ev, ev ? m_mask[s] : 8'd0, ev ? m_cap[s] : 8'd0, ek[494:0]});
    chk(req, 512'(lk_key[511:495]), 512'(ek[511:495]));
  endtask

  task automatic program_slot(int s, int seed, logic [7:0] mk, logic [7:0] cp);
    wr(adr(s, 16), 32'd0);
    for (int d = 0; d < 16; d++) wr(adr(s, d), 32'(seed * 32'h01010101 + d));
    wr(adr(s, 17), 32'hA500_0000 | 32'(seed));
    wr(adr(s, 16), {1'b1, 15'd0, cp, mk});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0; lk_slot = '0;
    rst = 1'b1;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R8 reset state
    rd_check("R8 reset key", adr(5, 3));
    rd_check("R8 reset ctrl", adr(0, 16));
    rd_check("R8 reset aux", adr(7, 17));
    lk_check("R8 reset lookup", 0);
    // R1 capability word and write-ignore
    rd_check("R1 cap", 12'h000);
    wr(12'h000, 32'hFFFF_FFFF);
    rd_check("R1 cap after write", 12'h000);

    // R2/R3/R4 ordered programming
    program_slot(2, 7, 8'h08, 8'h03);
    rd_check("R2 key dw0", adr(2, 0));
    rd_check("R2 key dw15", adr(2, 15));
    rd_check("R2 aux", adr(2, 17));
    rd_check("R3 ctrl", adr(2, 16));
    lk_check("R4 lookup armed", 2);
    chk("R4 second half at dword 8", 512'(lk_key[32*8 +: 32]), 512'(m_key[2][8]));
    wr(adr(4, 16), 32'h7FFF_5A3C);
    rd_check("R3 reserved bits zero", adr(4, 16));

    // R11 other slot untouched
    program_slot(3, 9, 8'h01, 8'h00);
    lk_check("R11 slot2 intact", 2);
    lk_check("R11 slot3 armed", 3);

    // R6 dword 17 keeps arming, key write disarms
    wr(adr(2, 17), 32'h1234_5678);
    lk_check("R6 aux keeps enable", 2);
    wr(adr(2, 5), 32'hDEAD_BEEF);
    rd_check("R6 ctrl shows disarm", adr(2, 16));
    lk_check("R6 lookup disarmed", 2);
    wr(adr(2, 16), {1'b1, 15'd0, 8'h03, 8'h08});
    lk_check("R6 rearmed", 2);

    // R10 same-edge write and lookup
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = adr(2, 0); bus_wdata = 32'hCAFE_0001; lk_slot = 4'd2;
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R10 old valid", 512'(lk_valid), 512'(1));
    chk("R10 old key", 512'(lk_key[31:0]), 512'(m_key[2][0]));
    model_write(adr(2, 0), 32'hCAFE_0001);
    @(negedge clk);
    chk("R10 next edge invalid", 512'(lk_valid), 512'(0));

    // R7 disarm and evict
    wr(adr(3, 16), 32'h0000_0101);
    lk_check("R7 disarm", 3);
    wr(adr(3, 16), 32'd0);
    for (int d = 0; d < 18; d++) wr(adr(3, d), 32'd0);
    rd_check("R7 evicted key", adr(3, 4));
    rd_check("R7 evicted ctrl", adr(3, 16));
    lk_check("R7 evicted lookup", 3);

    // R5 out of range slots
    program_slot(7, 3, 8'h10, 8'h02);
    lk_check("R5 top slot armed", 7);
    for (int s = NS; s < 16; s++) lk_check("R5 out of range", s);
    lk_check("R5 disabled slot", 4);

    // R9 writes outside decode
    wr(12'h080, 32'h1111_1111);
    wr(adr(1, 20), 32'h2222_2222);
    wr(AW'(BASE + NS * 128), 32'h3333_3333);
    rd_check("R9 gap", 12'h080);
    rd_check("R9 unused dword", adr(1, 20));
    rd_check("R9 beyond array", AW'(BASE + NS * 128));
    rd_check("R9 neighbours intact", adr(1, 16));

    // random mix
    for (int it = 0; it < 600; it++) begin
      int op = int'($urandom % 4);
      int s  = int'($urandom % 3) + 5 * int'($urandom % 2);
      int d  = int'($urandom % 20);
      logic [AW-1:0] a = ($urandom % 8 == 0) ? AW'(($urandom % 1024) * 4) : adr(s % NS, d);
      if (op == 0) wr(a, $urandom);
      else if (op == 1) wr(adr(s % NS, 16), $urandom);
      else if (op == 2) rd_check("R2 random read", a);
      else lk_check("R11 random lookup", int'($urandom % 10));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule